// File: doc/BRIEF.md
# Dual-Master Shared RAM Arbiter

This block lets a main CPU and a coprocessor share a group of single-port RAM blocks. Each master has a synchronous port with request, write enable, address, write data, read data and ready. The upper address bits pick a RAM block and the lower bits pick a word inside it. Each block is checked for contention on its own. When both masters target the same block in the same cycle, one master proceeds. The other sees ready low and keeps its request steady for one cycle, and its access then completes.

Each block is given one of four behaviours at build time:
- **Round-robin data block.** The winner alternates with conflict history.
- **Upstream mailbox.** A coprocessor write to this block never waits.
- **Downstream mailbox.** A coprocessor read from this block never waits.
- **Coprocessor program store.** The CPU cannot reach this block at all.

Blocks are independent. Two accesses to different blocks always proceed in the same cycle.

Top module: `dual_master_ram_arb`

## Requirements
- R1: After reset, both ready outputs are high while neither master requests, both read-data outputs are zero, and every round-robin block favours the CPU at its first conflict.
- R2: In a round-robin block (kind code 0), a conflict is won by the favoured master. After every cycle in which both masters request that block, the favoured master becomes the one that lost. No other cycle changes it.
- R3: Contention is judged per block. Two requests to the same block conflict even when their word addresses differ.
- R4: A losing access sees ready low for exactly one cycle. With its inputs held, it is granted on the next cycle ahead of any fresh request from the other master, in every kind of block.
- R5: Requests from the two masters to different blocks in the same cycle both see ready high.
- R6: In an upstream mailbox block (kind code 1, block 1 by default), a fresh coprocessor write beats a fresh CPU access. A fresh coprocessor read loses to a fresh CPU access.
- R7: In a downstream mailbox block (kind code 2, block 2 by default), a fresh coprocessor read beats a fresh CPU access. A fresh coprocessor write loses to a fresh CPU access.
- R8: A coprocessor program block (kind code 3, block 3 by default) serves the coprocessor without ever stalling it. A CPU access to that block completes at once with ready high. A CPU write there leaves memory unchanged, and a CPU read there returns zero.
- R9: Read data of a granted read appears on the master's read-data output one clock edge after the grant and holds until that master's next completed read. A write is stored at the edge of the cycle in which it is granted.
- R10: Block kinds come from one parameter that holds two bits per block, with block b at bits [2b+1:2b]. The block index is the top log2(NBLK) address bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | CPU access request |
| cpu_we | input | 1 | CPU write enable |
| cpu_addr | input | log2(NBLK)+WW | CPU address: block index over word index |
| cpu_wdata | input | DW | CPU write data |
| cpu_rdata | output | DW | CPU read data, one cycle after grant |
| cpu_ready | output | 1 | CPU access completes this cycle |
| cop_req | input | 1 | Coprocessor access request |
| cop_we | input | 1 | Coprocessor write enable |
| cop_addr | input | log2(NBLK)+WW | Coprocessor address |
| cop_wdata | input | DW | Coprocessor write data |
| cop_rdata | output | DW | Coprocessor read data, one cycle after grant |
| cop_ready | output | 1 | Coprocessor access completes this cycle |

## Verification
Ready is combinational, so it is due in the same cycle as the request. Read data is due one rising edge after the cycle in which ready was high for a read. The bench drives inputs on the falling edge and samples ready 1 ns later. It samples read data 1 ns after the following rising edge, so each check sees exactly the cycle its requirement names. In the random phase the bench keeps a stalled request's inputs unchanged and flags any second consecutive stall. It compares each completed read against a word model that is updated only on cycles in which ready was high.

// File: rtl/dmra_pkg.sv
package dmra_pkg;

   typedef enum logic [1:0] {
      KIND_RR    = 2'd0,
      KIND_UPMSG = 2'd1,
      KIND_DNMSG = 2'd2,
      KIND_PROG  = 2'd3
   } blk_kind_e;

   function automatic blk_kind_e kind_of(input logic [63:0] kinds, input int idx);
      return blk_kind_e'(kinds[2*idx +: 2]);
   endfunction

endpackage

// File: rtl/dmra_cell.sv
module dmra_cell #(
   parameter dmra_pkg::blk_kind_e KIND = dmra_pkg::KIND_RR
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cpu_hit,
   input  logic cop_hit,
   input  logic cop_we,
   input  logic cpu_hold,
   input  logic cop_hold,
   output logic cpu_gnt,
   output logic cop_gnt
);
   import dmra_pkg::*;

   logic rr_q;
   logic both;
   logic base_cop;
   logic pick_cop;

   assign both = cpu_hit & cop_hit;

   always_comb begin
      case (KIND)
         KIND_RR:    base_cop = rr_q;
         KIND_UPMSG: base_cop = cop_we;
         KIND_DNMSG: base_cop = !cop_we;
         default:    base_cop = 1'b1;
      endcase
   end

   // a master left waiting last cycle outranks any fresh request
   assign pick_cop = cpu_hold ? 1'b0 : (cop_hold ? 1'b1 : base_cop);

   assign cpu_gnt = cpu_hit & !(cop_hit & pick_cop);
   assign cop_gnt = cop_hit & !(cpu_hit & !pick_cop);

   // rr_q high means the coprocessor is favoured at the next conflict
   always_ff @(posedge clk) begin
      if (!rst_n)    rr_q <= 1'b0;
      else if (both) rr_q <= !pick_cop;
   end

endmodule

// File: rtl/dmra_bank.sv
module dmra_bank #(
   parameter int WW = 4,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          cpu_gnt,
   input  logic          cop_gnt,
   input  logic          cpu_we,
   input  logic          cop_we,
   input  logic [WW-1:0] cpu_word,
   input  logic [WW-1:0] cop_word,
   input  logic [DW-1:0] cpu_wdata,
   input  logic [DW-1:0] cop_wdata,
   output logic [DW-1:0] rd
);
   localparam int DEPTH = 1 << WW;

   logic [DW-1:0] mem [DEPTH];
   logic [WW-1:0] sel_word;
   logic [DW-1:0] wr_data;
   logic          wr_en;

   assign sel_word = cop_gnt ? cop_word  : cpu_word;
   assign wr_data  = cop_gnt ? cop_wdata : cpu_wdata;
   assign wr_en    = (cpu_gnt & cpu_we) | (cop_gnt & cop_we);

   always_ff @(posedge clk) begin
      if (wr_en) mem[sel_word] <= wr_data;
   end

   assign rd = mem[sel_word];

endmodule

// File: rtl/dmra_port.sv
module dmra_port #(
   parameter int             NBLK      = 4,
   parameter int             WW        = 4,
   parameter int             DW        = 16,
   parameter logic [2*NBLK-1:0] BLK_KINDS = '0,
   parameter bit             IS_CPU    = 1'b1,
   localparam int            BW        = $clog2(NBLK),
   localparam int            AW        = BW + WW
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req,
   input  logic               we,
   input  logic [AW-1:0]      addr,
   input  logic [NBLK-1:0]    gnt_v,
   input  logic [NBLK*DW-1:0] rd_flat,
   output logic [NBLK-1:0]    hit_v,
   output logic [WW-1:0]      word,
   output logic               hold,
   output logic               ready,
   output logic [DW-1:0]      rdata
);
   import dmra_pkg::*;

   localparam logic [63:0] KINDS64 = 64'(BLK_KINDS);

   logic [BW-1:0] blk;
   logic          barred;
   logic          hold_q;
   logic [DW-1:0] rdata_q;

   assign blk    = addr[AW-1 -: BW];
   assign word   = addr[WW-1:0];
   assign barred = IS_CPU && (kind_of(KINDS64, int'(blk)) == KIND_PROG);
   assign hit_v  = (req && !barred) ? (NBLK'(1) << blk) : '0;
   assign ready  = !req || barred || gnt_v[blk];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_q  <= 1'b0;
         rdata_q <= '0;
      end else begin
         hold_q <= req & !ready;
         if (req && !we && ready)
            rdata_q <= barred ? '0 : rd_flat[int'(blk)*DW +: DW];
      end
   end

   assign hold  = hold_q;
   assign rdata = rdata_q;

endmodule

// File: rtl/dual_master_ram_arb.sv
module dual_master_ram_arb #(
   parameter int                NBLK      = 4,
   parameter int                WW        = 4,
   parameter int                DW        = 16,
   parameter logic [2*NBLK-1:0] BLK_KINDS = 8'b11_10_01_00,
   localparam int               BW        = $clog2(NBLK),
   localparam int               AW        = BW + WW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cpu_req,
   input  logic          cpu_we,
   input  logic [AW-1:0] cpu_addr,
   input  logic [DW-1:0] cpu_wdata,
   output logic [DW-1:0] cpu_rdata,
   output logic          cpu_ready,
   input  logic          cop_req,
   input  logic          cop_we,
   input  logic [AW-1:0] cop_addr,
   input  logic [DW-1:0] cop_wdata,
   output logic [DW-1:0] cop_rdata,
   output logic          cop_ready
);
   import dmra_pkg::*;

   if (NBLK < 2 || NBLK > 32 || (NBLK & (NBLK - 1)) != 0) begin : g_bad_nblk
      $error("NBLK must be a power of two between 2 and 32");
   end
   if (WW < 1 || WW > 10) begin : g_bad_ww
      $error("WW must lie between 1 and 10");
   end
   if (DW < 1) begin : g_bad_dw
      $error("DW must be positive");
   end

   logic [NBLK-1:0]    cpu_hit_v, cop_hit_v;
   logic [NBLK-1:0]    cpu_gnt_v, cop_gnt_v;
   logic [NBLK*DW-1:0] rd_flat;
   logic [WW-1:0]      cpu_word, cop_word;
   logic               cpu_hold, cop_hold;

   dmra_port #(.NBLK(NBLK), .WW(WW), .DW(DW), .BLK_KINDS(BLK_KINDS), .IS_CPU(1'b1)) u_cpu (
      .clk(clk), .rst_n(rst_n), .req(cpu_req), .we(cpu_we), .addr(cpu_addr),
      .gnt_v(cpu_gnt_v), .rd_flat(rd_flat), .hit_v(cpu_hit_v), .word(cpu_word),
      .hold(cpu_hold), .ready(cpu_ready), .rdata(cpu_rdata));

   dmra_port #(.NBLK(NBLK), .WW(WW), .DW(DW), .BLK_KINDS(BLK_KINDS), .IS_CPU(1'b0)) u_cop (
      .clk(clk), .rst_n(rst_n), .req(cop_req), .we(cop_we), .addr(cop_addr),
      .gnt_v(cop_gnt_v), .rd_flat(rd_flat), .hit_v(cop_hit_v), .word(cop_word),
      .hold(cop_hold), .ready(cop_ready), .rdata(cop_rdata));

   for (genvar b = 0; b < NBLK; b++) begin : g_blk
      localparam blk_kind_e KIND = blk_kind_e'(BLK_KINDS[2*b +: 2]);

      dmra_cell #(.KIND(KIND)) u_cell (
         .clk(clk), .rst_n(rst_n),
         .cpu_hit(cpu_hit_v[b]), .cop_hit(cop_hit_v[b]), .cop_we(cop_we),
         .cpu_hold(cpu_hold), .cop_hold(cop_hold),
         .cpu_gnt(cpu_gnt_v[b]), .cop_gnt(cop_gnt_v[b]));

      dmra_bank #(.WW(WW), .DW(DW)) u_bank (
         .clk(clk),
         .cpu_gnt(cpu_gnt_v[b]), .cop_gnt(cop_gnt_v[b]),
         .cpu_we(cpu_we), .cop_we(cop_we),
         .cpu_word(cpu_word), .cop_word(cop_word),
         .cpu_wdata(cpu_wdata), .cop_wdata(cop_wdata),
         .rd(rd_flat[b*DW +: DW]));
   end

endmodule

// File: rtl/dmra_chk.sv
module dmra_chk #(
   parameter int                NBLK      = 4,
   parameter int                WW        = 4,
   parameter logic [2*NBLK-1:0] BLK_KINDS = 8'b11_10_01_00,
   localparam int               BW        = $clog2(NBLK),
   localparam int               AW        = BW + WW
) (
   input logic            clk,
   input logic            rst_n,
   input logic            cpu_req,
   input logic            cpu_we,
   input logic [AW-1:0]   cpu_addr,
   input logic            cpu_ready,
   input logic            cop_req,
   input logic            cop_we,
   input logic [AW-1:0]   cop_addr,
   input logic            cop_ready,
   input logic [NBLK-1:0] cpu_gnt_v,
   input logic [NBLK-1:0] cop_gnt_v
);
   import dmra_pkg::*;

   localparam logic [63:0] KINDS64 = 64'(BLK_KINDS);

   logic [BW-1:0] cpu_blk, cop_blk;
   logic          same_blk;
   blk_kind_e     cpu_kind, cop_kind;

   assign cpu_blk  = cpu_addr[AW-1 -: BW];
   assign cop_blk  = cop_addr[AW-1 -: BW];
   assign same_blk = cpu_blk == cop_blk;
   assign cpu_kind = kind_of(KINDS64, int'(cpu_blk));
   assign cop_kind = kind_of(KINDS64, int'(cop_blk));

   AST_GRANT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(cpu_gnt_v & cop_gnt_v) == 0); // R3

   AST_CPU_ONE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_req && !cpu_ready |=> cpu_ready); // R4

   AST_COP_ONE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      cop_req && !cop_ready |=> cop_ready); // R4

   AST_SPLIT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_req && cop_req && !same_blk |-> cpu_ready && cop_ready); // R5

   AST_UPMSG_COP_WR: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_req && cop_req && same_blk && cop_kind == KIND_UPMSG && cop_we
      && !$past(cpu_req && !cpu_ready) |-> cop_ready && !cpu_ready); // R6

   AST_DNMSG_COP_RD: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_req && cop_req && same_blk && cop_kind == KIND_DNMSG && !cop_we
      && !$past(cpu_req && !cpu_ready) |-> cop_ready && !cpu_ready); // R7

   AST_PROG_COP_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      cop_req && cop_kind == KIND_PROG |-> cop_ready); // R8

   AST_PROG_CPU_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_req && cpu_kind == KIND_PROG |-> cpu_ready); // R8

endmodule

bind dual_master_ram_arb dmra_chk #(.NBLK(NBLK), .WW(WW), .BLK_KINDS(BLK_KINDS)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_ready(cpu_ready),
   .cop_req(cop_req), .cop_we(cop_we), .cop_addr(cop_addr), .cop_ready(cop_ready),
   .cpu_gnt_v(cpu_gnt_v), .cop_gnt_v(cop_gnt_v));

// File: tb/dual_master_ram_arb_test.sv
module dual_master_ram_arb_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_req = 1'b0, cpu_we = 1'b0, cop_req = 1'b0, cop_we = 1'b0;
   logic [5:0]  cpu_addr = '0, cop_addr = '0;
   logic [15:0] cpu_wdata = '0, cop_wdata = '0;
   logic [15:0] cpu_rdata, cop_rdata;
   logic        cpu_ready, cop_ready;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   dual_master_ram_arb uut (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
      .cop_req(cop_req), .cop_we(cop_we), .cop_addr(cop_addr), .cop_wdata(cop_wdata),
      .cop_rdata(cop_rdata), .cop_ready(cop_ready));

   typedef struct packed {
      logic [3:0]  rq;
      logic        cq;  logic cw;  logic [5:0] ca; logic [15:0] cd;
      logic        pq;  logic pw;  logic [5:0] pa; logic [15:0] pd;
      logic        ecr; logic epr;
      logic        ccr; logic [15:0] ecd;
      logic        cpr; logic [15:0] epd;
   } vec_t;

   // addresses: {block[1:0], word[3:0]}; block0 RR, 1 upstream mailbox, 2 downstream mailbox, 3 program
   localparam vec_t VECS [14] = '{
      '{4'd3, 1'b1,1'b1,6'h01,16'h1111, 1'b1,1'b1,6'h02,16'h2222, 1'b1,1'b0, 1'b0,16'h0000, 1'b0,16'h0000}, // R2 R3 cpu favoured first
      '{4'd4, 1'b0,1'b0,6'h00,16'h0000, 1'b1,1'b1,6'h02,16'h2222, 1'b1,1'b1, 1'b0,16'h0000, 1'b0,16'h0000}, // R4 cop retry
      '{4'd2, 1'b1,1'b0,6'h02,16'h0000, 1'b1,1'b0,6'h01,16'h0000, 1'b0,1'b1, 1'b0,16'h0000, 1'b1,16'h1111}, // R2 cop favoured, R9
      '{4'd5, 1'b1,1'b0,6'h02,16'h0000, 1'b1,1'b1,6'h10,16'hAAAA, 1'b1,1'b1, 1'b1,16'h2222, 1'b0,16'h0000}, // R5 R4
      '{4'd6, 1'b1,1'b1,6'h13,16'h3333, 1'b1,1'b1,6'h14,16'h4444, 1'b0,1'b1, 1'b0,16'h0000, 1'b0,16'h0000}, // R6 cop write wins
      '{4'd4, 1'b1,1'b1,6'h13,16'h3333, 1'b1,1'b0,6'h14,16'h0000, 1'b1,1'b0, 1'b0,16'h0000, 1'b0,16'h0000}, // R4 held cpu wins
      '{4'd9, 1'b0,1'b0,6'h00,16'h0000, 1'b1,1'b0,6'h14,16'h0000, 1'b1,1'b1, 1'b0,16'h0000, 1'b1,16'h4444}, // R9 R6
      '{4'd7, 1'b1,1'b1,6'h25,16'h5555, 1'b1,1'b0,6'h25,16'h0000, 1'b0,1'b1, 1'b0,16'h0000, 1'b0,16'h0000}, // R7 cop read wins
      '{4'd7, 1'b1,1'b1,6'h25,16'h5555, 1'b1,1'b1,6'h26,16'h6666, 1'b1,1'b0, 1'b0,16'h0000, 1'b0,16'h0000}, // R7 R4 cop write loses
      '{4'd4, 1'b1,1'b0,6'h26,16'h0000, 1'b1,1'b1,6'h26,16'h6666, 1'b0,1'b1, 1'b0,16'h0000, 1'b0,16'h0000}, // R4 held cop wins
      '{4'd9, 1'b1,1'b0,6'h26,16'h0000, 1'b0,1'b0,6'h00,16'h0000, 1'b1,1'b1, 1'b1,16'h6666, 1'b0,16'h0000}, // R9 R4
      '{4'd8, 1'b1,1'b1,6'h30,16'h7777, 1'b1,1'b0,6'h30,16'h0000, 1'b1,1'b1, 1'b0,16'h0000, 1'b0,16'h0000}, // R8 barred write
      '{4'd8, 1'b1,1'b0,6'h30,16'h0000, 1'b1,1'b1,6'h30,16'h8888, 1'b1,1'b1, 1'b1,16'h0000, 1'b0,16'h0000}, // R8 barred read
      '{4'd8, 1'b0,1'b0,6'h00,16'h0000, 1'b1,1'b0,6'h30,16'h0000, 1'b1,1'b1, 1'b0,16'h0000, 1'b1,16'h8888}  // R8 R10
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic drive(input logic cq, input logic cw, input logic [5:0] ca, input logic [15:0] cd,
                        input logic pq, input logic pw, input logic [5:0] pa, input logic [15:0] pd);
      cpu_req = cq; cpu_we = cw; cpu_addr = ca; cpu_wdata = cd;
      cop_req = pq; cop_we = pw; cop_addr = pa; cop_wdata = pd;
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (60000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   logic [15:0] mdl [64];
   bit          mval [64];

   initial begin
      string tag;
      bit c_stall, p_stall, c_rd, p_rd;
      logic [15:0] c_exp, p_exp;

      for (int i = 0; i < 64; i++) mval[i] = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      #1;
      check("R1 cpu_ready idle", 32'(cpu_ready), 32'd1);
      check("R1 cop_ready idle", 32'(cop_ready), 32'd1);
      check("R1 cpu_rdata", 32'(cpu_rdata), 32'd0);
      check("R1 cop_rdata", 32'(cop_rdata), 32'd0);

      foreach (VECS[i]) begin
         @(negedge clk);
         drive(VECS[i].cq, VECS[i].cw, VECS[i].ca, VECS[i].cd,
               VECS[i].pq, VECS[i].pw, VECS[i].pa, VECS[i].pd);
         #1;
         tag = $sformatf("R%0d row %0d", VECS[i].rq, i);
         check({tag, " cpu_ready"}, 32'(cpu_ready), 32'(VECS[i].ecr));
         check({tag, " cop_ready"}, 32'(cop_ready), 32'(VECS[i].epr));
         @(posedge clk); #1;
         if (VECS[i].ccr) check({tag, " cpu_rdata"}, 32'(cpu_rdata), 32'(VECS[i].ecd));
         if (VECS[i].cpr) check({tag, " cop_rdata"}, 32'(cop_rdata), 32'(VECS[i].epd));
      end

      // random simultaneous traffic with a word model (R4, R9, R3)
      c_stall = 1'b0; p_stall = 1'b0;
      for (int n = 0; n < 4000; n++) begin
         @(negedge clk);
         if (!c_stall) begin
            cpu_req = ($urandom % 4) != 0; cpu_we = $urandom % 2;
            cpu_addr = 6'($urandom); cpu_wdata = 16'($urandom);
         end
         if (!p_stall) begin
            cop_req = ($urandom % 4) != 0; cop_we = $urandom % 2;
            cop_addr = 6'($urandom); cop_wdata = 16'($urandom);
         end
         #1;
         if (c_stall) check("R4 cpu second stall", 32'(cpu_ready), 32'd1);
         if (p_stall) check("R4 cop second stall", 32'(cop_ready), 32'd1);
         c_rd = 1'b0; p_rd = 1'b0; c_exp = '0; p_exp = '0;
         if (cpu_req && cpu_ready && !cpu_we) begin
            if (cpu_addr[5:4] == 2'd3) begin c_rd = 1'b1; c_exp = '0; end
            else if (mval[cpu_addr]) begin c_rd = 1'b1; c_exp = mdl[cpu_addr]; end
         end
         if (cop_req && cop_ready && !cop_we && mval[cop_addr]) begin
            p_rd = 1'b1; p_exp = mdl[cop_addr];
         end
         if (cpu_req && cpu_ready && cpu_we && cpu_addr[5:4] != 2'd3) begin
            mdl[cpu_addr] = cpu_wdata; mval[cpu_addr] = 1'b1;
         end
         if (cop_req && cop_ready && cop_we) begin
            mdl[cop_addr] = cop_wdata; mval[cop_addr] = 1'b1;
         end
         c_stall = cpu_req && !cpu_ready;
         p_stall = cop_req && !cop_ready;
         if (cpu_req && cop_req && cpu_addr[5:4] != cop_addr[5:4])
            check("R5 split blocks", 32'({cpu_ready, cop_ready}), 32'd3);
         @(posedge clk); #1;
         if (c_rd) check("R9 cpu read model", 32'(cpu_rdata), 32'(c_exp));
         if (p_rd) check("R9 cop read model", 32'(cop_rdata), 32'(p_exp));
      end

      // reset returns the round-robin pointer to the CPU (R1)
      @(negedge clk);
      drive(1'b0, 1'b0, 6'h00, 16'h0, 1'b0, 1'b0, 6'h00, 16'h0);
      rst_n = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      drive(1'b1, 1'b1, 6'h05, 16'hBEEF, 1'b1, 1'b1, 6'h06, 16'hCAFE);
      #1;
      check("R1 rr after reset cpu", 32'(cpu_ready), 32'd1);
      check("R1 rr after reset cop", 32'(cop_ready), 32'd0);
      @(negedge clk);
      drive(1'b1, 1'b0, 6'h05, 16'h0, 1'b1, 1'b1, 6'h06, 16'hCAFE);
      #1;
      check("R2 pointer moved to cop", 32'({cpu_ready, cop_ready}), 32'd1);
      @(negedge clk);
      drive(1'b1, 1'b0, 6'h05, 16'h0, 1'b0, 1'b0, 6'h00, 16'h0);
      #1;
      check("R4 cpu retry", 32'(cpu_ready), 32'd1);
      @(posedge clk); #1;
      check("R9 cpu read after retry", 32'(cpu_rdata), 32'h0000BEEF);
      @(negedge clk);
      drive(1'b0, 1'b0, 6'h00, 16'h0, 1'b0, 1'b0, 6'h00, 16'h0);
      finish_run();
   end

endmodule